// File: doc/BRIEF.md
# Big-Endian Load-Store Alignment Unit

This unit sits between the memory stage of a 32-bit load-store pipeline and a word-wide data memory. The unit accepts one access per handshake. It forms the effective address from a base register value and a signed 16-bit displacement. It issues a word-aligned memory request with per-byte write strobes. For loads, it turns the word the memory returns one cycle later into a zero- or sign-extended 32-bit result. The pipeline gets absolute addressing by passing a zero base. It gets register-indirect addressing by passing a zero displacement.

Byte numbering is big endian: byte offset 0 within a word is bits 31:24. Every access must be naturally aligned. An access that breaks this rule is flagged and never reaches memory.

The request side is valid/ready. A request is taken in any cycle where `req_valid` and `req_ready` are both high. The load result side is also valid/ready. While `rsp_valid` is high and `rsp_ready` is low, the result and its error bit stay frozen, and `req_ready` stays low. A stalled result therefore blocks further requests rather than being lost. The memory side has fixed timing and no back-pressure. Read data is expected on `mem_rdata` in the cycle after the request.

Top module: `lsa_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits. On an accepted aligned access, `mem_req` is high in the same cycle, with `mem_addr` equal to that address with bits 1:0 cleared and `mem_we` equal to `req_we`.
- R2: `req_size` encodes 2'b00 = byte, 2'b01 = halfword, 2'b10 = word; 2'b11 is reserved. An accepted access is faulty when it is a halfword with address bit 0 set, a word with either of address bits 1:0 set, or a reserved size. A faulty access pulses `align_err` in its acceptance cycle and leaves `mem_req` low, so a faulty store alters no memory.
- R3: Store byte strobes `mem_be` (bit 3 = bits 31:24) are 4'b1000 shifted right by the offset for bytes, 4'b1100 (offset 0) or 4'b0011 (offset 2) for halfwords, and 4'b1111 for words.
- R4: Store data is placed on every lane. A byte is replicated in all four lanes. A halfword is copied into both halves. A word passes through unchanged.
- R5: Load extraction is big endian. Byte offset 0/1/2/3 selects bits 31:24/23:16/15:8/7:0. Halfword offset 0 selects bits 31:16, and offset 2 selects bits 15:0.
- R6: A byte or halfword load result is sign-extended when `req_signed` was 1 at request time, and zero-extended otherwise. Word loads are unaffected.
- R7: An accepted load produces exactly one result, with `rsp_valid` high in the cycle after acceptance. The result is extracted using the offset, size and signedness captured at acceptance, so loads may issue back to back. Stores produce no result.
- R8: A faulty load still produces its result one cycle after acceptance, with `rsp_err` = 1 and `rsp_data` = 0.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_err` hold their values and `req_ready` is low. The result is delivered once `rsp_ready` rises.
- R10: After reset, `rsp_valid` and `mem_req` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (see R2) |
| req_signed | input | 1 | Sign-extend a byte/halfword load |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-justified |
| align_err | output | 1 | Faulty access accepted this cycle |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_be | output | 4 | Byte strobes, bit 3 = most significant lane |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Read word, valid the cycle after the request |
| rsp_valid | output | 1 | Load result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 32 | Extended load result |
| rsp_err | output | 1 | Result belongs to a faulty load |

## Verification
The request path has no state, so a wrong lane or strobe computation shows at `mem_be` and `mem_wdata` in the very cycle of the request. The bench reads each stored word back through loads to confirm which bytes actually changed. The only state is the captured offset, size and signedness, together with the stall register. A corrupted capture appears as a wrong `rsp_data` exactly one cycle after the load. Back-to-back loads to different offsets expose a capture taken from the wrong request. A broken stall register shows either as `rsp_data` changing while `rsp_ready` is low or as `req_ready` rising too early. Both are visible within one or two cycles.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } lsa_size_e;

  // Capture of a load between acceptance and data return
  typedef struct packed {
    logic      live;
    logic      fault;
    logic      sgn;
    lsa_size_e size;
  } lsa_pend_t;

endpackage

// File: rtl/lsa_agen.sv
// Effective address generation and alignment check.
module lsa_agen
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int LANES  = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  lsa_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic [OFS_W-1:0]  ofs,
  output logic              fault
);

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign ea       = base + disp_ext;
  assign ofs      = ea[OFS_W-1:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: fault = 1'b0;
      SZ_HALF: fault = ofs[0];
      SZ_WORD: fault = |ofs;
      default: fault = 1'b1;
    endcase
  end

endmodule

// File: rtl/lsa_store_lanes.sv
// Byte strobes and lane placement for stores, big-endian numbering.
module lsa_store_lanes
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  lsa_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_data
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // Byte offset served by lane i (lane LANES-1 holds offset 0)
    localparam logic [OFS_W-1:0] LANE_OFS = OFS_W'(LANES - 1 - i);

    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          be[i]               = (LANE_OFS == ofs);
          lane_data[i*8 +: 8] = wdata[7:0];
        end
        SZ_HALF: begin
          be[i]               = (LANE_OFS[OFS_W-1:1] == ofs[OFS_W-1:1]);
          lane_data[i*8 +: 8] = wdata[(i % 2)*8 +: 8];
        end
        SZ_WORD: begin
          be[i]               = 1'b1;
          lane_data[i*8 +: 8] = wdata[i*8 +: 8];
        end
        default: begin
          be[i]               = 1'b0;
          lane_data[i*8 +: 8] = wdata[i*8 +: 8];
        end
      endcase
    end
  end

endmodule

// File: rtl/lsa_load_extract.sv
// Selects the addressed byte/halfword of a returned word and widens it.
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES),
  localparam int HALVES = LANES / 2
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFS_W-1:0]  ofs,
  input  lsa_size_e         size,
  input  logic              sgn,
  output logic [DATA_W-1:0] result
);

  logic [7:0]  byte_at [LANES];
  logic [15:0] half_at [HALVES];
  logic [7:0]  bsel;
  logic [15:0] hsel;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign byte_at[k] = rdata[(LANES-1-k)*8 +: 8];
  end

  for (genvar j = 0; j < HALVES; j++) begin : g_half
    assign half_at[j] = rdata[(LANES-2-2*j)*8 +: 16];
  end

  assign bsel = byte_at[ofs];
  assign hsel = half_at[ofs[OFS_W-1:1]];

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(DATA_W-8){sgn & bsel[7]}}, bsel};
      SZ_HALF: result = {{(DATA_W-16){sgn & hsel[15]}}, hsel};
      default: result = rdata;
    endcase
  end

endmodule

// File: rtl/lsa_unit.sv
// Load-store alignment unit: request handshake, memory strobes, load result.
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              align_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);

  lsa_size_e         size_in;
  logic [ADDR_W-1:0] ea;
  logic [OFS_W-1:0]  ofs;
  logic              fault;
  logic              take;

  lsa_pend_t         pend_q;
  logic [OFS_W-1:0]  pend_ofs_q;
  logic [DATA_W-1:0] ext_data;
  logic [DATA_W-1:0] live_data;
  logic              stall;

  logic              held_q;
  logic [DATA_W-1:0] held_data_q;
  logic              held_err_q;

  assign size_in = lsa_size_e'(req_size);

  lsa_agen #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .LANES  (LANES)
  ) u_agen (
    .base  (req_base),
    .disp  (req_disp),
    .size  (size_in),
    .ea    (ea),
    .ofs   (ofs),
    .fault (fault)
  );

  lsa_store_lanes #(
    .DATA_W (DATA_W)
  ) u_lanes (
    .size      (size_in),
    .ofs       (ofs),
    .wdata     (req_wdata),
    .be        (mem_be),
    .lane_data (mem_wdata)
  );

  // Request side
  assign stall     = pend_q.live & ~rsp_ready;
  assign req_ready = ~held_q & ~stall;
  assign take      = req_valid & req_ready;
  assign align_err = take & fault;
  assign mem_req   = take & ~fault;
  assign mem_we    = req_we;
  assign mem_addr  = {ea[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  // Load capture, one cycle until data return
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_ofs_q <= '0;
    end else begin
      pend_q.live <= take & ~req_we;
      if (take & ~req_we) begin
        pend_q.fault <= fault;
        pend_q.sgn   <= req_signed;
        pend_q.size  <= size_in;
        pend_ofs_q   <= ofs;
      end
    end
  end

  lsa_load_extract #(
    .DATA_W (DATA_W)
  ) u_extract (
    .rdata  (mem_rdata),
    .ofs    (pend_ofs_q),
    .size   (pend_q.size),
    .sgn    (pend_q.sgn),
    .result (ext_data)
  );

  assign live_data = pend_q.fault ? '0 : ext_data;

  // Stall register: holds a result the consumer has not taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q      <= 1'b0;
      held_data_q <= '0;
      held_err_q  <= 1'b0;
    end else if (stall) begin
      held_q      <= 1'b1;
      held_data_q <= live_data;
      held_err_q  <= pend_q.fault;
    end else if (held_q & rsp_ready) begin
      held_q <= 1'b0;
    end
  end

  assign rsp_valid = pend_q.live | held_q;
  assign rsp_data  = held_q ? held_data_q : live_data;
  assign rsp_err   = held_q ? held_err_q : pend_q.fault;

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [1:0]        req_size,
  input logic              align_err,
  input logic              mem_req,
  input logic              mem_we,
  input logic [LANES-1:0]  mem_be,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_err
);

  AST_ERR_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n) align_err |-> !mem_req); // R2
  AST_MEM_NEEDS_HS: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> (req_valid && req_ready && mem_we == req_we)); // R1
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && req_size == 2'b00) |-> $countones(mem_be) == 1); // R3
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && req_size == 2'b01) |-> $countones(mem_be) == 2); // R3
  AST_LOAD_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready && !req_we) |=> rsp_valid); // R7
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_err) |-> rsp_data == '0); // R8
  AST_RSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err))); // R9
  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |-> !req_ready); // R9

endmodule

bind lsa_unit lsa_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lsa_unit_bench.sv
`timescale 1ns/1ps
module lsa_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_signed = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_wdata = '0;
  logic        align_err;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] mem [16];

  always #5 clk = ~clk;

  lsa_unit u_lsa_unit (.*);

  // Memory model: registered read, byte-strobed write
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit we, input logic [1:0] sz, input bit sg,
                       input logic [31:0] base, input logic [15:0] disp, input logic [31:0] wd);
    req_valid = 1'b1; req_we = we; req_size = sz; req_signed = sg;
    req_base = base; req_disp = disp; req_wdata = wd;
  endtask

  // Store: check strobes/data/address in the request cycle
  task automatic t_store(input logic [1:0] sz, input logic [31:0] base, input logic [15:0] disp,
                         input logic [31:0] wd, input logic [31:0] exp_addr,
                         input logic [3:0] exp_be, input logic [31:0] exp_wd, input string tag);
    @(negedge clk);
    drive(1'b1, sz, 1'b0, base, disp, wd);
    #1;
    chk(mem_req && mem_we && !align_err, {tag, " R1 store issued"}, {29'd0, mem_req, mem_we, align_err}, 32'h6);
    chk(mem_addr == exp_addr, {tag, " R1 address"}, mem_addr, exp_addr);
    chk(mem_be == exp_be, {tag, " R3 strobes"}, {28'd0, mem_be}, {28'd0, exp_be});
    chk(mem_wdata == exp_wd, {tag, " R4 lane data"}, mem_wdata, exp_wd);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(!rsp_valid, {tag, " R7 store gives no result"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  // Load: result one cycle after acceptance
  task automatic t_load(input logic [1:0] sz, input bit sg, input logic [31:0] base,
                        input logic [15:0] disp, input logic [31:0] exp, input string tag);
    @(negedge clk);
    drive(1'b0, sz, sg, base, disp, '0);
    #1;
    chk(mem_req && !mem_we && !align_err, {tag, " R1 load issued"}, {29'd0, mem_req, mem_we, align_err}, 32'h4);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid && !rsp_err, {tag, " R7 result valid"}, {30'd0, rsp_valid, rsp_err}, 32'h2);
    chk(rsp_data == exp, {tag, " R5/R6 result"}, rsp_data, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(!rsp_valid && !mem_req && req_ready, "R10 reset state",
        {29'd0, rsp_valid, mem_req, req_ready}, 32'h1);
    rst_n = 1'b1;
  endtask

  task automatic t_faulty_store(input logic [1:0] sz, input logic [31:0] base, input string tag);
    @(negedge clk);
    drive(1'b1, sz, 1'b0, base, '0, 32'hDEADDEAD);
    #1;
    chk(align_err && !mem_req, {tag, " R2 fault flagged, no write"}, {30'd0, align_err, mem_req}, 32'h2);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(!align_err && !rsp_valid, {tag, " R2 pulse only"}, {30'd0, align_err, rsp_valid}, 32'h0);
  endtask

  task automatic t_faulty_load(input logic [1:0] sz, input logic [31:0] base, input string tag);
    @(negedge clk);
    drive(1'b0, sz, 1'b1, base, '0, '0);
    #1;
    chk(align_err && !mem_req, {tag, " R2 load fault"}, {30'd0, align_err, mem_req}, 32'h2);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid && rsp_err && rsp_data == 0, {tag, " R8 error result"}, rsp_data, 32'h0);
  endtask

  // Two loads in consecutive cycles with different offsets
  task automatic t_back_to_back;
    @(negedge clk);
    drive(1'b0, 2'b00, 1'b0, 32'h10, 16'h0003, '0);
    @(negedge clk);
    #1;
    chk(req_ready, "R7 ready while result taken", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid && rsp_data == 32'h44, "R7 first of pair", rsp_data, 32'h44);
    drive(1'b0, 2'b01, 1'b1, 32'h14, 16'h0000, '0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid && rsp_data == 32'hFFFF8070, "R7 R6 second of pair", rsp_data, 32'hFFFF8070);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    drive(1'b0, 2'b00, 1'b1, 32'h14, 16'h0003, '0);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid && rsp_data == 32'hFFFFFFEF, "R9 stalled result", rsp_data, 32'hFFFFFFEF);
    chk(!req_ready, "R9 request blocked", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    #1;
    chk(rsp_valid && rsp_data == 32'hFFFFFFEF, "R9 result held", rsp_data, 32'hFFFFFFEF);
    chk(!req_ready, "R9 still blocked", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    #1;
    chk(rsp_valid && rsp_data == 32'hFFFFFFEF, "R9 delivered", rsp_data, 32'hFFFFFFEF);
    @(negedge clk);
    #1;
    chk(!rsp_valid && req_ready, "R9 released", {30'd0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    t_reset();
    // negative displacement; absolute address via zero base
    t_store(2'b10, 32'h20, 16'hFFF0, 32'h11223344, 32'h10, 4'b1111, 32'h11223344, "word");
    t_store(2'b00, 32'h10, 16'h0001, 32'h000000AB, 32'h10, 4'b0100, 32'hABABABAB, "byte");
    t_store(2'b10, 32'h00, 16'h0014, 32'h80706050, 32'h14, 4'b1111, 32'h80706050, "abs");
    t_store(2'b01, 32'h16, 16'h0000, 32'h0000BEEF, 32'h14, 4'b0011, 32'hBEEFBEEF, "half2");
    t_store(2'b01, 32'h20, 16'h0000, 32'h00001234, 32'h20, 4'b1100, 32'h12341234, "half0");
    t_store(2'b00, 32'h23, 16'h0000, 32'h00000077, 32'h20, 4'b0001, 32'h77777777, "byte3");
    t_load(2'b10, 1'b0, 32'h10, 16'h0000, 32'h11AB3344, "R5 word");
    t_load(2'b00, 1'b0, 32'h10, 16'h0000, 32'h00000011, "R5 byte0");
    t_load(2'b00, 1'b1, 32'h10, 16'h0001, 32'hFFFFFFAB, "R6 signed byte");
    t_load(2'b00, 1'b0, 32'h10, 16'h0001, 32'h000000AB, "R6 unsigned byte");
    t_load(2'b01, 1'b1, 32'h12, 16'h0000, 32'h00003344, "R6 positive half");
    t_load(2'b01, 1'b1, 32'h16, 16'h0000, 32'hFFFFBEEF, "R6 signed half");
    t_load(2'b01, 1'b0, 32'h14, 16'h0000, 32'h00008070, "R5 unsigned half0");
    t_load(2'b00, 1'b0, 32'h17, 16'h0000, 32'h000000EF, "R5 byte3");
    t_load(2'b10, 1'b0, 32'h20, 16'h0000, 32'h12340077, "R3 partial writes");
    t_faulty_store(2'b01, 32'h13, "half odd");
    t_faulty_store(2'b10, 32'h12, "word off2");
    t_faulty_store(2'b11, 32'h10, "reserved");
    t_load(2'b10, 1'b0, 32'h10, 16'h0000, 32'h11AB3344, "R2 memory untouched");
    t_faulty_load(2'b10, 32'h11, "word off1");
    t_faulty_load(2'b11, 32'h14, "reserved");
    t_back_to_back();
    t_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule